// File: doc/BRIEF.md
# Machine Cycle Clock Rate Controller

This block turns a single input clock into the machine-cycle enable strobes used by a microcontroller core and by its peripheral timers. It has no clock outputs. Each strobe is a one-clock-wide enable that marks the last clock of a machine cycle. Three cycle lengths are available: a normal length of 4 clocks, and two slow lengths of 64 and 1024 clocks. In the slow lengths the processor keeps running, only more slowly, to save power. Firmware picks the length by writing the mode register. No hardware event can change it.

Firmware can also put the block into an idle state. In idle the processor strobe is held off, while the timer strobe keeps pulsing once every 4 clocks, whatever length is selected. A wake input, driven by the interrupt logic, ends idle. The processor strobe then comes back on the next boundary of the selected cycle length.

A rate change never cuts a machine cycle short. The cycle in progress always runs to its full length, and the new length applies from the cycle that follows it.

Top module: `mcc_rate_ctrl`

## Requirements
- R1: While reset is held, both strobes are low, `rate_o` reads 00 and `idle_o` reads 0. After reset is released, the first processor strobe appears in the 4th clock.
- R2: With rate code 00, the processor strobe pulses once every 4 clocks, and the timer strobe pulses in the same clocks.
- R3: Rate code 01 gives one processor strobe every 64 clocks and rate code 10 gives one every 1024 clocks. Outside idle, the timer strobe follows the same reduced rate.
- R4: Rate code 11 is reserved and runs at one strobe every 4 clocks, while `rate_o` reports 11.
- R5: Only a register write (`cfg_wr` high) can change the rate. Pulses on `wake` leave `rate_o` and the strobe period unchanged.
- R6: A write that lands inside a machine cycle leaves that cycle at its full length, and the new rate starts with the next cycle. A write made in the last clock of a cycle applies to the cycle that begins right after it. `rate_o` shows the active rate.
- R7: A write with `cfg_idle` high enters idle from the next clock. In idle the processor strobe stays low and the timer strobe pulses every 4 clocks at any rate.
- R8: `wake` clears idle on the next clock and takes priority over a write that sets idle in the same clock. The processor strobe resumes at the next boundary of the active rate.
- R9: Each strobe is one clock wide, and whenever the processor strobe is high the timer strobe is high too.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_rate | input | 2 | Rate code: 00 = /4, 01 = /64, 10 = /1024, 11 = /4 (reserved) |
| cfg_idle | input | 1 | Idle bit written together with the rate code |
| wake | input | 1 | Interrupt wake; clears idle |
| cpu_ce | output | 1 | Processor machine-cycle enable |
| tmr_ce | output | 1 | Timer machine-cycle enable |
| rate_o | output | 2 | Rate code currently in force |
| idle_o | output | 1 | Idle state |

## Verification
Two pairs of events can fall in the same clock, and each pair is provoked on purpose.

The first pair is a firmware rate write and a machine-cycle boundary. The bench issues a write in exactly the clock where the processor strobe is high. It then checks that `rate_o` switches on the next clock, and that the following strobe arrives after the full new period. A second write is placed mid-cycle, and the bench checks that the slow cycle it lands in still runs its full 1024 clocks.

The second pair is a wake and an idle-setting write. Both are asserted in one clock. The bench judges the outcome by `idle_o` staying low and by processor strobes continuing.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    typedef enum logic [1:0] {
        RATE_FAST = 2'b00,
        RATE_MID  = 2'b01,
        RATE_SLOW = 2'b10,
        RATE_RSVD = 2'b11
    } rate_e;

    // firmware-visible mode state
    typedef struct packed {
        rate_e rate;
        logic  idle;
    } mode_t;

    localparam int unsigned DEF_DIV_FAST = 4;
    localparam int unsigned DEF_DIV_MID  = 64;
    localparam int unsigned DEF_DIV_SLOW = 1024;

    // machine-cycle length in input clocks for a rate code
    function automatic int unsigned cycle_len(rate_e r, int unsigned f,
                                              int unsigned m, int unsigned s);
        case (r)
            RATE_MID:  return m;
            RATE_SLOW: return s;
            default:   return f;
        endcase
    endfunction

endpackage

// File: rtl/mcc_mode_reg.sv
module mcc_mode_reg
    import mcc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  rate_e wr_rate,
    input  logic  wr_idle,
    input  logic  wake,
    output rate_e sel_rate,
    output logic  idle
);

    mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q.rate <= RATE_FAST;
            mode_q.idle <= 1'b0;
        end else begin
            if (wr_en)
                mode_q.rate <= wr_rate;
            // wake overrides a simultaneous idle request
            if (wake)
                mode_q.idle <= 1'b0;
            else if (wr_en)
                mode_q.idle <= wr_idle;
        end
    end

    // a write in the boundary clock is forwarded so it applies at once
    assign sel_rate = wr_en ? wr_rate : mode_q.rate;
    assign idle     = mode_q.idle;

endmodule

// File: rtl/mcc_cycle_cnt.sv
module mcc_cycle_cnt
    import mcc_pkg::*;
#(
    parameter int unsigned DIV_FAST = DEF_DIV_FAST,
    parameter int unsigned DIV_MID  = DEF_DIV_MID,
    parameter int unsigned DIV_SLOW = DEF_DIV_SLOW
) (
    input  logic  clk,
    input  logic  rst,
    input  rate_e sel_rate,
    output rate_e act_rate,
    output logic  cyc_last,
    output logic  quarter
);

    localparam int CNT_W = $clog2(DIV_SLOW);
    localparam int Q_W   = $clog2(DIV_FAST);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    rate_e            act_q;

    always_comb begin
        lim = CNT_W'(cycle_len(act_q, DIV_FAST, DIV_MID, DIV_SLOW) - 1);
    end

    assign cyc_last = (cnt_q == lim);
    assign quarter  = (cnt_q[Q_W-1:0] == {Q_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= RATE_FAST;
        end else if (cyc_last) begin
            cnt_q <= '0;
            act_q <= sel_rate;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign act_rate = act_q;

endmodule

// File: rtl/mcc_strobe_gen.sv
module mcc_strobe_gen (
    input  logic cyc_last,
    input  logic quarter,
    input  logic idle,
    output logic cpu_ce,
    output logic tmr_ce
);

    always_comb begin
        cpu_ce = cyc_last & ~idle;
        tmr_ce = idle ? quarter : cyc_last;
    end

endmodule

// File: rtl/mcc_rate_ctrl.sv
module mcc_rate_ctrl
    import mcc_pkg::*;
#(
    parameter int unsigned DIV_FAST = DEF_DIV_FAST,
    parameter int unsigned DIV_MID  = DEF_DIV_MID,
    parameter int unsigned DIV_SLOW = DEF_DIV_SLOW
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_rate,
    input  logic       cfg_idle,
    input  logic       wake,
    output logic       cpu_ce,
    output logic       tmr_ce,
    output logic [1:0] rate_o,
    output logic       idle_o
);

    rate_e sel_rate;
    rate_e act_rate;
    logic  idle;
    logic  cyc_last;
    logic  quarter;

    mcc_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr),
        .wr_rate  (rate_e'(cfg_rate)),
        .wr_idle  (cfg_idle),
        .wake     (wake),
        .sel_rate (sel_rate),
        .idle     (idle)
    );

    mcc_cycle_cnt #(
        .DIV_FAST (DIV_FAST),
        .DIV_MID  (DIV_MID),
        .DIV_SLOW (DIV_SLOW)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .sel_rate (sel_rate),
        .act_rate (act_rate),
        .cyc_last (cyc_last),
        .quarter  (quarter)
    );

    mcc_strobe_gen u_strb (
        .cyc_last (cyc_last),
        .quarter  (quarter),
        .idle     (idle),
        .cpu_ce   (cpu_ce),
        .tmr_ce   (tmr_ce)
    );

    assign rate_o = act_rate;
    assign idle_o = idle;

endmodule

// File: rtl/mcc_rate_ctrl_chk.sv
module mcc_rate_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_wr,
    input logic       cfg_idle,
    input logic       wake,
    input logic       cpu_ce,
    input logic       tmr_ce,
    input logic [1:0] rate_o,
    input logic       idle_o,
    input logic       cyc_last
);

    // R9
    cpu_implies_tmr_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ce |-> tmr_ce);

    // R9
    cpu_one_wide_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ce |=> !cpu_ce);

    // R9
    tmr_one_wide_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_ce |=> !tmr_ce);

    // R7
    idle_blocks_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        idle_o |-> !cpu_ce);

    // R7
    idle_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_idle && !wake) |=> idle_o);

    // R8
    wake_clears_idle_chk: assert property (@(posedge clk) disable iff (rst)
        wake |=> !idle_o);

    // R6
    rate_holds_mid_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_last |=> $stable(rate_o));

endmodule

bind mcc_rate_ctrl mcc_rate_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_idle (cfg_idle),
    .wake     (wake),
    .cpu_ce   (cpu_ce),
    .tmr_ce   (tmr_ce),
    .rate_o   (rate_o),
    .idle_o   (idle_o),
    .cyc_last (cyc_last)
);

// File: tb/mcc_rate_ctrl_tb.sv
module mcc_rate_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_rate = 2'b00;
    logic       cfg_idle = 1'b0;
    logic       wake = 1'b0;
    logic       cpu_ce, tmr_ce, idle_o;
    logic [1:0] rate_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    mcc_rate_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rate(cfg_rate),
        .cfg_idle(cfg_idle), .wake(wake), .cpu_ce(cpu_ce), .tmr_ce(tmr_ce),
        .rate_o(rate_o), .idle_o(idle_o)
    );

    typedef struct packed {
        logic [1:0]  rate;
        logic        idle;
        logic [11:0] cpu_p;   // 0 = no processor strobe expected
        logic [11:0] tmr_p;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1'b0, 12'd4,    12'd4},
        '{2'd1, 1'b0, 12'd64,   12'd64},
        '{2'd2, 1'b0, 12'd1024, 12'd1024},
        '{2'd3, 1'b0, 12'd4,    12'd4},
        '{2'd1, 1'b1, 12'd0,    12'd4},
        '{2'd2, 1'b1, 12'd0,    12'd4},
        '{2'd0, 1'b1, 12'd0,    12'd4}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic fw_write(input logic [1:0] r, input logic i);
        cfg_wr = 1'b1; cfg_rate = r; cfg_idle = i;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_idle = 1'b0;
    endtask

    task automatic wait_rate(input logic [1:0] r);
        for (int k = 0; k < 3000 && rate_o != r; k++) @(negedge clk);
    endtask

    // negedges until next processor strobe, 0 on timeout
    task automatic wait_cpu(output int n, input int lim);
        n = 0;
        do begin @(negedge clk); n++; end while (!cpu_ce && n < lim);
        if (!cpu_ce) n = 0;
    endtask

    task automatic wait_tmr(output int n, input int lim);
        n = 0;
        do begin @(negedge clk); n++; end while (!tmr_ce && n < lim);
        if (!tmr_ce) n = 0;
    endtask

    function automatic string tag_of(input logic [1:0] r, input logic i);
        if (i) return "R7";
        case (r)
            2'd0: return "R2";
            2'd3: return "R4";
            default: return "R3";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int n, p;
        string tg;
        // R1 reset state
        repeat (3) tick();
        chk(!cpu_ce && !tmr_ce, "R1", "strobes in reset", int'(cpu_ce | tmr_ce), 0);
        chk(rate_o == 2'd0 && !idle_o, "R1", "mode in reset", int'({rate_o, idle_o}), 0);
        rst = 1'b0;
        wait_cpu(n, 10);
        chk(n == 3, "R1", "first strobe after reset", n, 3);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            tg = tag_of(VECS[i].rate, VECS[i].idle);
            fw_write(VECS[i].rate, VECS[i].idle);
            wait_rate(VECS[i].rate);
            chk(rate_o == VECS[i].rate, tg, "rate_o", rate_o, VECS[i].rate);
            chk(idle_o == VECS[i].idle, tg, "idle_o", idle_o, VECS[i].idle);
            wait_tmr(n, 3000);
            wait_tmr(p, 3000);
            chk(p == int'(VECS[i].tmr_p), tg, "timer period", p, VECS[i].tmr_p);
            if (VECS[i].cpu_p == 0) begin
                wait_cpu(n, 2100);
                chk(n == 0, tg, "cpu strobe in idle", n, 0);
                wake = 1'b1; tick(); wake = 1'b0;
                chk(!idle_o, "R8", "idle after wake", idle_o, 0);
                wait_cpu(n, 3000);
                wait_cpu(p, 3000);
                chk(p == int'(cycle_of(VECS[i].rate)), "R8", "cpu period after wake",
                    p, cycle_of(VECS[i].rate));
            end else begin
                wait_cpu(n, 3000);
                chk(tmr_ce, "R9", "timer with cpu strobe", tmr_ce, 1);
                wait_cpu(p, 3000);
                chk(p == int'(VECS[i].cpu_p), tg, "cpu period", p, VECS[i].cpu_p);
            end
        end

        // R6 write mid slow cycle keeps the cycle whole
        fw_write(2'd2, 1'b0);
        wait_rate(2'd2);
        wait_cpu(n, 3000);
        repeat (10) tick();
        fw_write(2'd0, 1'b0);
        chk(rate_o == 2'd2, "R6", "rate mid cycle", rate_o, 2);
        wait_cpu(p, 3000);
        chk(p == 1013, "R6", "remaining slow cycle", p, 1013);
        wait_cpu(p, 3000);
        chk(p == 4, "R6", "period after switch", p, 4);

        // R6 write in the boundary clock applies immediately
        wait_cpu(n, 100);
        fw_write(2'd1, 1'b0);
        chk(!cpu_ce, "R9", "cpu strobe width", cpu_ce, 0);
        chk(rate_o == 2'd1, "R6", "boundary write rate", rate_o, 1);
        wait_cpu(p, 3000);
        chk(p == 63, "R6", "first cycle after boundary write", p, 63);

        // R8 wake beats idle write in the same clock
        cfg_wr = 1'b1; cfg_rate = 2'd1; cfg_idle = 1'b1; wake = 1'b1;
        tick();
        cfg_wr = 1'b0; cfg_idle = 1'b0; wake = 1'b0;
        chk(!idle_o, "R8", "wake vs idle write", idle_o, 0);
        wait_cpu(n, 70);
        chk(n != 0, "R8", "cpu strobe continues", n, 1);

        // R5 wake pulses never move the rate
        n = 0;
        for (int k = 0; k < 200; k++) begin
            wake = 1'b1; tick();
            if (rate_o != 2'd1) n++;
        end
        wake = 1'b0;
        chk(n == 0, "R5", "rate changes from wake", n, 0);
        wait_cpu(n, 100);
        wait_cpu(p, 100);
        chk(p == 64, "R5", "period after wake pulses", p, 64);

        // R8 wake mid idle resumes on the slow boundary
        repeat (5) tick();
        fw_write(2'd1, 1'b1);
        repeat (10) tick();
        wake = 1'b1; tick(); wake = 1'b0;
        wait_cpu(n, 100);
        chk(n == 47, "R8", "resume on boundary", n, 47);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    function automatic int cycle_of(input logic [1:0] r);
        case (r)
            2'd1: return 64;
            2'd2: return 1024;
            default: return 4;
        endcase
    endfunction

endmodule